// File: doc/BRIEF.md
# Fixed-Point Signed Gain Stage

This block scales a stream of signed samples by a programmable signed gain. Samples are 16-bit two's complement with one sign bit and 15 fraction bits, so codes -32768..32767 stand for -1 up to just under +1. The gain is a 6-bit two's complement code with one sign bit and 5 fraction bits. It steps by 0.03125 from -1 to 0.96875, so +1.0 has no code. The gain sits in a register that a load strobe writes.

The multiply keeps the full 22-bit product, which has 2 integer bits and 20 fraction bits. The result is then brought back to the sample format. The top product bit carries information in only one case: the most negative sample times the most negative gain, which is exactly +1.0. In every other case that bit only repeats the sign, so it is dropped and no precision is lost. A mode input decides how the one out-of-range case is resolved, by clamping or by modulo wrap. A sticky flag records that it happened. The datapath has two register stages and never stalls.

Top module: `fxgain_stage`

## Requirements
- R1: With no overflow, each accepted sample s and active gain code g give outSample = floor((s*g + 16) / 32). This is product bits [20:5] rounded on the bits below bit 5.
- R2: outValid is high in cycle n+2 exactly when inValid was high in cycle n. The output takes one new result for each accepted sample, with no backpressure.
- R3: Rounding is half-up toward +infinity. A discarded remainder of exactly 16/32 rounds up, so a raw product of 16 gives 1 and a raw product of -16 gives 0.
- R4: When satMode is 1 for a sample of -32768 with gain code -32, the output is 32767.
- R5: When satMode is 0 for a sample of -32768 with gain code -32, the output is the low 16 bits of the rounded result, -32768.
- R6: ovfSticky becomes 1 on the cycle a clamped or wrapped result appears and stays 1 until a clear strobe (ovfClear high for one cycle, effective the next cycle). If a new overflow result appears in the same cycle as the clear takes effect, the set wins.
- R7: gainLoad writes gainCode into the gain register. A sample accepted in the same cycle as the load still uses the previous gain. Every sample accepted from the next cycle on uses the new gain.
- R8: After reset, outValid, outSample and ovfSticky are 0 and the gain register holds code 0, so samples accepted before any load give 0.
- R9: In cycles where no result arrives, outSample keeps its last value.
- R10: Sample 7668 with gain code 10 forms a raw product of 76680 and gives outSample 2396.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample is present this cycle |
| inSample | input | 16 | Signed sample, 1 sign bit and 15 fraction bits |
| gainLoad | input | 1 | Write gainCode into the gain register |
| gainCode | input | 6 | Signed gain, 1 sign bit and 5 fraction bits |
| satMode | input | 1 | Overflow handling for this sample: 1 clamp, 0 wrap |
| ovfClear | input | 1 | Clear the sticky overflow flag |
| outValid | output | 1 | outSample holds a new result |
| outSample | output | 16 | Scaled sample, 1 sign bit and 15 fraction bits |
| ovfSticky | output | 1 | A clamped or wrapped result has appeared since the last clear |

## Verification
The assertions watch, on every cycle, the valid pipeline, the hold of the gain register between loads, the load itself, the hold of the output between results, the clamp and wrap values for the corner product, and the flag's persistence. Whether the arithmetic is right can only be shown by the bench's scenarios. That covers rounding ties on both signs, results over the whole gain range against a spread of samples, the known 7668 by 10 case, and the timing of a load relative to a sample. The bench also tests the case where the set and clear of the flag land in the same cycle.

// File: rtl/fxgain_pkg.sv
`timescale 1ns/1ps
package fxgain_pkg;

  // Strobes from control to the multiply stage
  typedef struct packed {
    logic loadGain;
    logic stage1En;
  } mulStrobes_t;

  // Strobes from control to the requantize stage
  typedef struct packed {
    logic stage2En;
    logic clearOvf;
  } reqStrobes_t;

endpackage

// File: rtl/fxgain_ctrl.sv
`timescale 1ns/1ps
module fxgain_ctrl
  import fxgain_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        gainLoad,
  input  logic        ovfClear,
  output mulStrobes_t mulStb,
  output reqStrobes_t reqStb,
  output logic        outValid
);

  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    mulStb.loadGain = gainLoad;
    mulStb.stage1En = inValid;
    reqStb.stage2En = s1Valid;
    reqStb.clearOvf = ovfClear;
  end

  assign outValid = s2Valid;

  AST_VALID_STAGE1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> s1Valid); // R2
  AST_IDLE_STAGE1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !s1Valid); // R2
  AST_VALID_OUT: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> outValid); // R2
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> !outValid); // R2

endmodule

// File: rtl/fxgain_mult.sv
`timescale 1ns/1ps
module fxgain_mult
  import fxgain_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6,
  localparam int PROD_W  = SAMPLE_W + GAIN_W
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  mulStrobes_t              mulStb,
  input  logic [SAMPLE_W-1:0]      inSample,
  input  logic [GAIN_W-1:0]        gainCode,
  input  logic                     satMode,
  output logic signed [PROD_W-1:0] prodQ,
  output logic                     satQ
);

  logic [GAIN_W-1:0]        gainQ;
  logic signed [PROD_W-1:0] sampleExt;
  logic signed [PROD_W-1:0] gainExt;
  logic signed [PROD_W-1:0] prodNext;

  // Gain register: a same-cycle sample still sees the old value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainQ <= '0;
    end else if (mulStb.loadGain) begin
      gainQ <= gainCode;
    end
  end

  always_comb begin
    sampleExt = {{GAIN_W{inSample[SAMPLE_W-1]}}, inSample};
    gainExt   = {{SAMPLE_W{gainQ[GAIN_W-1]}}, gainQ};
    prodNext  = sampleExt * gainExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ <= '0;
      satQ  <= 1'b0;
    end else if (mulStb.stage1En) begin
      prodQ <= prodNext;
      satQ  <= satMode;
    end
  end

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !mulStb.loadGain |=> $stable(gainQ)); // R7
  AST_GAIN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    mulStb.loadGain |=> gainQ == $past(gainCode)); // R7

endmodule

// File: rtl/fxgain_requant.sv
`timescale 1ns/1ps
module fxgain_requant
  import fxgain_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6,
  localparam int PROD_W  = SAMPLE_W + GAIN_W
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  reqStrobes_t              reqStb,
  input  logic signed [PROD_W-1:0] prodQ,
  input  logic                     satQ,
  output logic [SAMPLE_W-1:0]      outSample,
  output logic                     ovfSticky
);

  localparam int SHIFT   = GAIN_W - 1;
  localparam int OUT_MAX = 2 ** (SAMPLE_W - 1) - 1;
  localparam int OUT_MIN = -(2 ** (SAMPLE_W - 1));
  localparam logic signed [PROD_W-1:0] MAX_P = PROD_W'(OUT_MAX);
  localparam logic signed [PROD_W-1:0] MIN_P = PROD_W'(OUT_MIN);
  localparam logic signed [PROD_W-1:0] ROUND_BIAS = PROD_W'(2 ** (SHIFT - 1));
  localparam logic [PROD_W-1:0] CORNER = {2'b01, {(PROD_W-2){1'b0}}};
  localparam logic [SAMPLE_W-1:0] OUT_MAX_S = SAMPLE_W'(OUT_MAX);
  localparam logic [SAMPLE_W-1:0] OUT_MIN_S = SAMPLE_W'(OUT_MIN);

  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] rounded;
  logic                     overHigh;
  logic                     overLow;
  logic [SAMPLE_W-1:0]      resultNext;

  always_comb begin
    biased   = prodQ + ROUND_BIAS;
    rounded  = biased >>> SHIFT;
    overHigh = rounded > MAX_P;
    overLow  = rounded < MIN_P;
    if (satQ && overHigh) begin
      resultNext = OUT_MAX_S;
    end else if (satQ && overLow) begin
      resultNext = OUT_MIN_S;
    end else begin
      resultNext = rounded[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSample <= '0;
    end else if (reqStb.stage2En) begin
      outSample <= resultNext;
    end
  end

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfSticky <= 1'b0;
    end else if (reqStb.stage2En && (overHigh || overLow)) begin
      ovfSticky <= 1'b1;
    end else if (reqStb.clearOvf) begin
      ovfSticky <= 1'b0;
    end
  end

  AST_CORNER_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    reqStb.stage2En && satQ && (prodQ == CORNER) |=> outSample == OUT_MAX_S); // R4
  AST_CORNER_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    reqStb.stage2En && !satQ && (prodQ == CORNER) |=> outSample == OUT_MIN_S); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    reqStb.stage2En && (prodQ == CORNER) |=> ovfSticky); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ovfSticky && !reqStb.clearOvf |=> ovfSticky); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqStb.stage2En |=> $stable(outSample)); // R9

endmodule

// File: rtl/fxgain_stage.sv
`timescale 1ns/1ps
module fxgain_stage
  import fxgain_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                gainLoad,
  input  logic [GAIN_W-1:0]   gainCode,
  input  logic                satMode,
  input  logic                ovfClear,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                ovfSticky
);

  localparam int PROD_W = SAMPLE_W + GAIN_W;

  mulStrobes_t              mulStb;
  reqStrobes_t              reqStb;
  logic signed [PROD_W-1:0] prodQ;
  logic                     satQ;

  fxgain_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .gainLoad (gainLoad),
    .ovfClear (ovfClear),
    .mulStb   (mulStb),
    .reqStb   (reqStb),
    .outValid (outValid)
  );

  fxgain_mult #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) uMult (
    .clk      (clk),
    .rstN     (rstN),
    .mulStb   (mulStb),
    .inSample (inSample),
    .gainCode (gainCode),
    .satMode  (satMode),
    .prodQ    (prodQ),
    .satQ     (satQ)
  );

  fxgain_requant #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) uRequant (
    .clk       (clk),
    .rstN      (rstN),
    .reqStb    (reqStb),
    .prodQ     (prodQ),
    .satQ      (satQ),
    .outSample (outSample),
    .ovfSticky (ovfSticky)
  );

endmodule

// File: tb/fxgain_stage_test.sv
`timescale 1ns/1ps
module fxgain_stage_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic        gainLoad = 1'b0;
  logic [5:0]  gainCode = '0;
  logic        satMode = 1'b0;
  logic        ovfClear = 1'b0;
  logic        outValid;
  logic [15:0] outSample;
  logic        ovfSticky;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench-side model of what should appear, two slots deep
  bit    slotV [2];
  int    slotS [2];
  bit    slotO [2];
  string slotT [2];
  int    curGain = 0;
  int    lastOut = 0;
  bit    expFlag = 0;
  bit    prevClr = 0;

  always #2 clk = ~clk;

  fxgain_stage uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .gainLoad(gainLoad), .gainCode(gainCode), .satMode(satMode),
    .ovfClear(ovfClear), .outValid(outValid), .outSample(outSample),
    .ovfSticky(ovfSticky)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected scaled value; ovf set when clamp or wrap changed it
  function automatic int refScale(input int s, input int g, input bit sat, output bit ovf);
    int p;
    int r;
    p = s * g;
    r = (p + 16) >>> 5;
    ovf = 0;
    if (r > 32767) begin
      ovf = 1;
      r = sat ? 32767 : r - 65536;
    end else if (r < -32768) begin
      ovf = 1;
      r = sat ? -32768 : r + 65536;
    end
    return r;
  endfunction

  task automatic step(input bit v, input int s, input bit ld, input int g,
                      input bit sat, input bit clr, input string tag);
    bit ovf;
    int r;
    @(negedge clk);
    if (slotV[1] && slotO[1]) expFlag = 1;
    else if (prevClr) expFlag = 0;
    check(outValid == slotV[1], "R2 outValid", int'(outValid), int'(slotV[1]));
    if (slotV[1]) begin
      lastOut = slotS[1];
      check(int'($signed(outSample)) == lastOut, slotT[1], int'($signed(outSample)), lastOut);
    end else begin
      check(int'($signed(outSample)) == lastOut, "R9 hold", int'($signed(outSample)), lastOut);
    end
    check(ovfSticky == expFlag, "R6 flag", int'(ovfSticky), int'(expFlag));
    r = refScale(s, curGain, sat, ovf);
    slotV[1] = slotV[0]; slotS[1] = slotS[0]; slotO[1] = slotO[0]; slotT[1] = slotT[0];
    slotV[0] = v; slotS[0] = r; slotO[0] = v && ovf; slotT[0] = tag;
    if (ld) curGain = g;
    inValid  = v;
    inSample = 16'(s);
    gainLoad = ld;
    gainCode = 6'(g);
    satMode  = sat;
    ovfClear = clr;
    prevClr  = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin slotV[i] = 0; slotS[i] = 0; slotO[i] = 0; slotT[i] = ""; end
    repeat (3) @(negedge clk);
    // R8: reset state
    check(outValid == 1'b0, "R8 outValid", int'(outValid), 0);
    check(outSample == 16'd0, "R8 outSample", int'(outSample), 0);
    check(ovfSticky == 1'b0, "R8 ovfSticky", int'(ovfSticky), 0);
    rstN = 1'b1;

    // R8: gain resets to code 0
    step(1, 12345, 0, 0, 1, 0, "R8 gain zero");
    step(1, -32768, 0, 0, 1, 0, "R8 gain zero");
    idle(3);

    // R10: known product
    step(0, 0, 1, 10, 1, 0, "R10");
    step(1, 7668, 0, 0, 1, 0, "R10 7668x10");
    idle(3);

    // R7: load in same cycle as a sample, then the next sample
    step(1, 1000, 1, 5, 1, 0, "R7 old gain");
    step(1, 1000, 0, 0, 1, 0, "R7 new gain");
    step(1, -1000, 1, -7, 1, 0, "R7 old gain");
    step(1, -1000, 0, 0, 1, 0, "R7 new gain");
    idle(3);

    // R3: rounding ties and near-ties with gain 1
    step(0, 0, 1, 1, 1, 0, "R3");
    step(1, 16, 0, 0, 1, 0, "R3 tie pos");
    step(1, -16, 0, 0, 1, 0, "R3 tie neg");
    step(1, 48, 0, 0, 1, 0, "R3 tie pos");
    step(1, -48, 0, 0, 1, 0, "R3 tie neg");
    step(1, 15, 0, 0, 1, 0, "R3 below");
    step(1, 17, 0, 0, 1, 0, "R3 above");
    step(1, -17, 0, 0, 1, 0, "R3 neg");
    idle(3);

    // R1: every gain code against a spread of samples, streaming
    for (int g = -32; g < 32; g++) begin
      step(0, 0, 1, g, 0, 0, "R1");
      for (int i = 0; i < 256; i++)
        step(1, -32768 + i * 257, 0, 0, (g % 2) == 0, 0, "R1 sweep");
      step(1, -1, 0, 0, 1, 0, "R1 sweep");
      step(1, 1, 0, 0, 0, 0, "R1 sweep");
    end
    idle(3);

    // Clear the flag left by the sweep
    step(0, 0, 0, 0, 0, 1, "R6");
    idle(3);

    // R4: clamp
    step(0, 0, 1, -32, 1, 0, "R4");
    step(1, -32768, 0, 0, 1, 0, "R4 clamp");
    idle(4);
    step(0, 0, 0, 0, 0, 1, "R6 clear");
    idle(3);
    // R5: wrap
    step(1, -32768, 0, 0, 0, 0, "R5 wrap");
    idle(4);
    // R6: clear and set collide, set must win
    step(0, 0, 0, 0, 0, 1, "R6 clear");
    step(1, -32768, 0, 0, 1, 0, "R4 clamp");
    step(0, 0, 0, 0, 0, 1, "R6 collide");
    idle(4);
    // No overflow just below the corner
    step(0, 0, 0, 0, 0, 1, "R6 clear");
    step(1, -32767, 0, 0, 0, 0, "R1 near corner");
    step(1, 32767, 0, 0, 0, 0, "R1 near corner");
    idle(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule